// File: doc/BRIEF.md
# Raster Position Counter Readout

This block converts the raster generator's internal beam position into the two 8-bit counters that a processor reads to locate the beam. The internal position is a row, from 0 up to one less than the frame's line count, and a column, from 0 to 341. The vertical counter is a registered, remapped view of the row. It switches to the new row part way into the line. It also jumps back at fixed points that depend on the refresh standard and on how many active lines the frame shows. The horizontal counter comes from a column value captured on a strobe. That value is rebased so that pixel zero reads as zero, and then halved.

A timing generator elsewhere supplies the row and column every clock. The readout logic only observes them. The standard select, the active-line code and the strobe come from the register side of the display controller.

Top module: `beampos_counter`

## Requirements
- R1: While reset is asserted and after its release with no further inputs, vcount_o reads 0x00 and hcount_o reads 0x80, because the held column is cleared to 0.
- R2: The vertical counter is registered and shows, one clock after the inputs, a source row. While col_i is below 63 the source row is the previous row: row_i minus one, with row 0 becoming the last line of the frame. The last line is 261 when pal_i is 0 (60 Hz, 262 lines) and 312 when pal_i is 1 (50 Hz, 313 lines). From column 63 on, the source row is row_i itself.
- R3: With pal_i = 0 and act_i = 0 or 3 (192 active lines), source rows of 219 (0xDB) or more read 6 lower.
- R4: With pal_i = 0 and act_i = 1 (224 active lines), source rows of 235 (0xEB) or more read 6 lower.
- R5: With pal_i = 0 and act_i = 2 (240 active lines), the source row is not adjusted. In every mode vcount_o holds only the low 8 bits of the adjusted row, so values above 0xFF wrap.
- R6: With pal_i = 1 and act_i = 2 (240 active lines), source rows of 267 or more read 0x39 lower.
- R7: With pal_i = 1 and act_i = 1 (224 active lines), source rows of 259 or more read 0x39 lower.
- R8: With pal_i = 1 and act_i = 0 or 3 (192 active lines), source rows of 243 (0xF3) or more read 0x39 lower.
- R9: hcount_o is derived from the held column C as follows. Take C minus 86. If that is below -46, add 342. Shift the result right by one with the sign kept, and output its low 8 bits.
- R10: The held column loads col_i at a clock edge where hlatch_i is 1, and hcount_o shows the new value after that edge. At an edge where hlatch_i is 0 the held column, and so hcount_o, is unchanged whatever col_i does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_i | input | 9 | Current raster row |
| col_i | input | 9 | Current raster column, 0 to 341 |
| pal_i | input | 1 | Standard select: 0 = 60 Hz, 1 = 50 Hz |
| act_i | input | 2 | Active lines: 0 or 3 = 192, 1 = 224, 2 = 240 |
| hlatch_i | input | 1 | Strobe that captures the current column |
| vcount_o | output | 8 | Vertical counter value |
| hcount_o | output | 8 | Horizontal counter value |

## Verification
The assertions assume that col_i always stays below 342. They also assume that row_i stays below the line count of the standard in force at that moment, since a row beyond the frame has no defined reading. The driver only picks rows from 0 up to the last line of the selected standard and columns from 0 to 341. It also switches the standard and the active-line code only together with a fresh row and column. A checker on the input ranges guards that contract.

// File: rtl/beampos_pkg.sv
package beampos_pkg;

   typedef enum logic [1:0] {
      ACT_192     = 2'd0,
      ACT_224     = 2'd1,
      ACT_240     = 2'd2,
      ACT_192_ALT = 2'd3
   } act_lines_e;

   // Jump-back thresholds and step sizes per standard
   localparam int NTSC_THR_192 = 219;
   localparam int NTSC_THR_224 = 235;
   localparam int NTSC_STEP    = 6;
   localparam int PAL_THR_240  = 267;
   localparam int PAL_THR_224  = 259;
   localparam int PAL_THR_192  = 243;
   localparam int PAL_STEP     = 57;

   function automatic logic is_192(input act_lines_e a);
      return (a == ACT_192) || (a == ACT_192_ALT);
   endfunction

endpackage

// File: rtl/beampos_row_select.sv
module beampos_row_select #(
   parameter int ROW_W      = 9,
   parameter int COL_W      = 9,
   parameter int SWITCH_COL = 63,
   parameter int NTSC_LINES = 262,
   parameter int PAL_LINES  = 313
) (
   input  logic [ROW_W-1:0] row_i,
   input  logic [COL_W-1:0] col_i,
   input  logic             pal_i,
   output logic [ROW_W-1:0] src_row_o
);

   localparam logic [ROW_W-1:0] NTSC_LAST = ROW_W'(NTSC_LINES - 1);
   localparam logic [ROW_W-1:0] PAL_LAST  = ROW_W'(PAL_LINES - 1);
   localparam logic [COL_W-1:0] SWITCH    = COL_W'(SWITCH_COL);

   logic [ROW_W-1:0] last_row;
   logic             early;

   always_comb begin
      last_row = pal_i ? PAL_LAST : NTSC_LAST;
      early    = (col_i < SWITCH);
      if (!early) begin
         src_row_o = row_i;
      end else if (row_i == '0) begin
         src_row_o = last_row;
      end else begin
         src_row_o = row_i - ROW_W'(1);
      end
   end

endmodule

// File: rtl/beampos_row_remap.sv
module beampos_row_remap
   import beampos_pkg::*;
#(
   parameter int ROW_W         = 9,
   parameter int OUT_W         = 8,
   parameter bit PAL192_ADJUST = 1'b1
) (
   input  logic [ROW_W-1:0] src_row_i,
   input  logic             pal_i,
   input  act_lines_e       act_i,
   output logic [OUT_W-1:0] vcount_o
);

   logic             pal192_en;
   logic             adj_en;
   logic [ROW_W-1:0] thr;
   logic [ROW_W-1:0] step;
   logic [ROW_W-1:0] adjusted;

   // Variant choice: whether 50 Hz with 192 lines also jumps back
   generate
      if (PAL192_ADJUST) begin : g_pal192_on
         assign pal192_en = 1'b1;
      end else begin : g_pal192_off
         assign pal192_en = 1'b0;
      end
   endgenerate

   always_comb begin
      adj_en = 1'b0;
      thr    = '0;
      step   = '0;
      if (pal_i) begin
         step = ROW_W'(PAL_STEP);
         if (act_i == ACT_240) begin
            adj_en = 1'b1;
            thr    = ROW_W'(PAL_THR_240);
         end else if (act_i == ACT_224) begin
            adj_en = 1'b1;
            thr    = ROW_W'(PAL_THR_224);
         end else begin
            adj_en = pal192_en;
            thr    = ROW_W'(PAL_THR_192);
         end
      end else begin
         step = ROW_W'(NTSC_STEP);
         if (act_i == ACT_224) begin
            adj_en = 1'b1;
            thr    = ROW_W'(NTSC_THR_224);
         end else if (is_192(act_i)) begin
            adj_en = 1'b1;
            thr    = ROW_W'(NTSC_THR_192);
         end
      end
      adjusted = (adj_en && (src_row_i >= thr)) ? (src_row_i - step) : src_row_i;
      vcount_o = adjusted[OUT_W-1:0];
   end

endmodule

// File: rtl/beampos_hpos.sv
module beampos_hpos #(
   parameter int COL_W      = 9,
   parameter int OUT_W      = 8,
   parameter int PIX_START  = 86,
   parameter int WRAP_LIMIT = 46,
   parameter int LINE_COLS  = 342
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [COL_W-1:0] col_i,
   input  logic             strobe_i,
   output logic [OUT_W-1:0] hcount_o
);

   localparam int SW = COL_W + 2;
   localparam logic signed [SW-1:0] K_START = SW'(PIX_START);
   localparam logic signed [SW-1:0] K_LIMIT = -SW'(WRAP_LIMIT);
   localparam logic signed [SW-1:0] K_LINE  = SW'(LINE_COLS);

   logic [COL_W-1:0]        lat_q;
   logic signed [SW-1:0]    rel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_q <= '0;
      end else if (strobe_i) begin
         lat_q <= col_i;
      end
   end

   always_comb begin
      rel = $signed({2'b00, lat_q}) - K_START;
      if (rel < K_LIMIT) begin
         rel = rel + K_LINE;
      end
      hcount_o = rel[OUT_W:1];
   end

   p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_i |=> $stable(lat_q))
      else $error("held column changed without strobe");

   p_latch_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_i |=> (lat_q == $past(col_i)))
      else $error("held column missed strobe sample");

   p_pixel_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i && col_i == COL_W'(PIX_START)) |=> (hcount_o == '0))
      else $error("pixel start column not read as zero");

endmodule

// File: rtl/beampos_counter.sv
module beampos_counter
   import beampos_pkg::*;
#(
   parameter int ROW_W         = 9,
   parameter int COL_W         = 9,
   parameter int OUT_W         = 8,
   parameter int LINE_COLS     = 342,
   parameter int SWITCH_COL    = 63,
   parameter int PIX_START     = 86,
   parameter int WRAP_LIMIT    = 46,
   parameter int NTSC_LINES    = 262,
   parameter int PAL_LINES     = 313,
   parameter bit PAL192_ADJUST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ROW_W-1:0] row_i,
   input  logic [COL_W-1:0] col_i,
   input  logic             pal_i,
   input  logic [1:0]       act_i,
   input  logic             hlatch_i,
   output logic [OUT_W-1:0] vcount_o,
   output logic [OUT_W-1:0] hcount_o
);

   // Elaboration-time parameter checks
   generate
      if (PAL_LINES > (1 << ROW_W) || NTSC_LINES > (1 << ROW_W)) begin : g_bad_row_w
         $error("ROW_W too narrow for line count");
      end
      if (LINE_COLS > (1 << COL_W)) begin : g_bad_col_w
         $error("COL_W too narrow for line length");
      end
      if (OUT_W + 1 > COL_W + 1) begin : g_bad_out_w
         $error("OUT_W too wide for column path");
      end
   endgenerate

   act_lines_e       act_e;
   logic [ROW_W-1:0] src_row;
   logic [OUT_W-1:0] vnext;
   logic [OUT_W-1:0] vcount_q;

   assign act_e = act_lines_e'(act_i);

   beampos_row_select #(
      .ROW_W(ROW_W), .COL_W(COL_W), .SWITCH_COL(SWITCH_COL),
      .NTSC_LINES(NTSC_LINES), .PAL_LINES(PAL_LINES)
   ) u_rowsel (
      .row_i(row_i), .col_i(col_i), .pal_i(pal_i), .src_row_o(src_row)
   );

   beampos_row_remap #(
      .ROW_W(ROW_W), .OUT_W(OUT_W), .PAL192_ADJUST(PAL192_ADJUST)
   ) u_remap (
      .src_row_i(src_row), .pal_i(pal_i), .act_i(act_e), .vcount_o(vnext)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vcount_q <= '0;
      end else begin
         vcount_q <= vnext;
      end
   end

   assign vcount_o = vcount_q;

   beampos_hpos #(
      .COL_W(COL_W), .OUT_W(OUT_W), .PIX_START(PIX_START),
      .WRAP_LIMIT(WRAP_LIMIT), .LINE_COLS(LINE_COLS)
   ) u_hpos (
      .clk(clk), .rst_n(rst_n), .col_i(col_i), .strobe_i(hlatch_i), .hcount_o(hcount_o)
   );

   // Input contract
   p_col_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      col_i < COL_W'(LINE_COLS))
      else $error("column beyond line length");

   p_row_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      row_i < (pal_i ? ROW_W'(PAL_LINES) : ROW_W'(NTSC_LINES)))
      else $error("row beyond frame");

   // Behaviour across the row path
   p_ntsc240_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!pal_i && act_i == 2'd2 && col_i >= COL_W'(SWITCH_COL))
      |=> (vcount_o == $past(row_i[OUT_W-1:0])))
      else $error("unadjusted row not passed through");

   p_first_row_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!pal_i && act_i == 2'd2 && col_i < COL_W'(SWITCH_COL) && row_i == '0)
      |=> (vcount_o == OUT_W'(NTSC_LINES - 1)))
      else $error("row zero early did not show last line");

   p_pal240_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pal_i && act_i == 2'd2 && col_i >= COL_W'(SWITCH_COL) && row_i >= ROW_W'(PAL_THR_240))
      |=> (vcount_o == OUT_W'($past(row_i) - ROW_W'(PAL_STEP))))
      else $error("50 Hz 240-line jump missing");

endmodule

// File: tb/beampos_counter_tb.sv
module beampos_counter_tb;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] row = '0;
   logic [8:0] col = 9'd100;
   logic       pal = 1'b0;
   logic [1:0] act = 2'd2;
   logic       hlatch = 1'b0;
   logic [7:0] vcount;
   logic [7:0] hcount;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 0;
   int model_lat = 0;

   logic [15:0] q_exp[$];
   string       q_tag[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   beampos_counter u_dut (
      .clk(clk), .rst_n(rst_n), .row_i(row), .col_i(col), .pal_i(pal),
      .act_i(act), .hlatch_i(hlatch), .vcount_o(vcount), .hcount_o(hcount)
   );

   function automatic int exp_v(int r, int c, bit p, int a);
      int tot = p ? 313 : 262;
      int s;
      s = (c < 63) ? ((r == 0) ? tot - 1 : r - 1) : r;
      if (!p) begin
         if ((a == 0 || a == 3) && s >= 'hDB) s -= 6;
         if (a == 1 && s >= 'hEB) s -= 6;
      end else begin
         if (a == 2 && s >= 267) s -= 'h39;
         if (a == 1 && s >= 259) s -= 'h39;
         if ((a == 0 || a == 3) && s >= 'hF3) s -= 'h39;
      end
      return s & 'hFF;
   endfunction

   function automatic int exp_h(int lat);
      int pc = lat - 86;
      if (pc < -46) pc += 342;
      return (pc >>> 1) & 'hFF;
   endfunction

   task automatic check(string tag, int got, int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, got, exp);
      end
   endtask

   // Driver: one stimulus per clock, expected results queued
   task automatic drive(int r, int c, bit p, int a, bit s, string tag);
      @(negedge clk);
      row = 9'(r); col = 9'(c); pal = p; act = 2'(a); hlatch = s;
      if (s) model_lat = c;
      q_exp.push_back({8'(exp_v(r, c, p, a)), 8'(exp_h(model_lat))});
      q_tag.push_back(tag);
   endtask

   // Monitor: compares one queued item after each edge
   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (q_exp.size() > 0) begin
         logic [15:0] e;
         string t;
         e = q_exp.pop_front();
         t = q_tag.pop_front();
         check({t, " vcount"}, vcount, e[15:8]);
         check({t, " hcount"}, hcount, e[7:0]);
      end
   end

   task automatic finish_run();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #(CLK_PERIOD/4);
      check("R1 reset", vcount, 0);
      check("R1 reset", hcount, 'h80);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #(CLK_PERIOD/4);
      check("R1 after release", hcount, 'h80);

      // R2: row switch point and previous-row wrap
      drive(5, 62, 0, 2, 0, "R2 early col");
      drive(5, 63, 0, 2, 0, "R2 switch col");
      drive(0, 10, 0, 2, 0, "R2 ntsc row0 wrap");
      drive(0, 0, 1, 2, 0, "R2 pal row0 wrap");
      // R5: pass-through and 8-bit wrap
      drive(100, 100, 0, 2, 0, "R5 mid row");
      drive(261, 200, 0, 2, 0, "R5 wrap");
      // R3 / R4
      drive(218, 100, 0, 0, 0, "R3 below");
      drive(219, 100, 0, 0, 0, "R3 at thr");
      drive(219, 100, 0, 3, 0, "R3 alt code");
      drive(234, 100, 0, 1, 0, "R4 below");
      drive(235, 100, 0, 1, 0, "R4 at thr");
      // R6 / R7 / R8
      drive(266, 100, 1, 2, 0, "R6 below");
      drive(267, 100, 1, 2, 0, "R6 at thr");
      drive(258, 100, 1, 1, 0, "R7 below");
      drive(259, 100, 1, 1, 0, "R7 at thr");
      drive(242, 100, 1, 0, 0, "R8 below");
      drive(243, 100, 1, 0, 0, "R8 at thr");
      drive(243, 100, 1, 3, 0, "R8 alt code");

      // R9: horizontal conversion corners
      drive(10, 0, 0, 2, 1, "R9 col 0");
      drive(10, 39, 0, 2, 1, "R9 col 39");
      drive(10, 40, 0, 2, 1, "R9 col 40");
      drive(10, 86, 0, 2, 1, "R9 col 86");
      drive(10, 87, 0, 2, 1, "R9 col 87");
      drive(10, 341, 0, 2, 1, "R9 col 341");
      drive(10, 150, 0, 2, 1, "R9 col 150");
      // R10: no strobe, column moves, reading must hold
      drive(10, 200, 0, 2, 0, "R10 hold a");
      drive(10, 5, 0, 2, 0, "R10 hold b");
      drive(10, 300, 0, 2, 1, "R10 reload");

      // Sweep every row in every mode, both sides of the switch column
      for (int p = 0; p < 2; p++) begin
         for (int a = 0; a < 4; a++) begin
            for (int r = 0; r < (p ? 313 : 262); r++) begin
               drive(r, (r % 2) ? 62 : 64, p[0], a, r % 7 == 0,
                     p ? "R6 R7 R8 sweep" : "R3 R4 R5 sweep");
            end
         end
      end
      for (int c = 0; c < 342; c++) begin
         drive(20, c, 0, 2, 1, "R9 column sweep");
      end

      repeat (3) @(posedge clk);
      #(CLK_PERIOD/2);
      done = 1;
      finish_run();
   end

endmodule